// File: doc/BRIEF.md
# Hibernation Wake and Power Sequencer

This block decides when the rest of the chip loses and regains power. It runs its timing from a slow 32.768 kHz reference clock. When software raises a hibernate request, the sequencer first withdraws its core-ready flag. It then drives the active-low `hib_n` output low, which switches off the external voltage regulators. While the chip is hibernating, the sequencer watches the active-low `wake_n` pin. A low level that persists long enough counts as a wake. The sequencer then releases `hib_n` inside a bounded window. It waits a fixed settling interval for the supplies to reach operating level, and only then raises core-ready again.

The block also times writes to its retained registers. Each write strobe from the system side starts a busy interval, measured in reference cycles, while the slow storage completes. A hibernate request that arrives during that interval is dropped. All decisions are made in the reference-clock domain. Both the request and the pin pass through two-flop synchronizers on the way in. The core-ready and busy flags cross back into the system-clock domain for software to read.

Top module: `hib_power_seq`

## Requirements
- R1: When reset is released, `hib_n` is high, `core_ready` is high and `wr_busy` is low.
- R2: While hibernating, a `wake_n` low level seen at only one reference rising edge is discarded and `hib_n` stays low. A low level seen at two consecutive reference rising edges is accepted as a wake.
- R3: When `wake_n` falls between two reference edges, `hib_n` stays low through the third reference rising edge that follows. It goes high on the fourth, which keeps the release inside the 2 to 4 cycle window.
- R4: A rising hibernate request, raised between reference edges while awake and not busy, drops `core_ready` on the third reference rising edge that follows. It drives `hib_n` low on the fourth. `hib_n` never falls in the same cycle as `core_ready`.
- R5: A one-cycle `reg_wr` strobe makes `wr_busy` rise within 4 reference cycles. It then stays high for exactly 3 reference cycles.
- R6: `core_ready` rises 9 reference cycles after `hib_n` goes high, and it is never high while `hib_n` is low.
- R7: A hibernate request whose rising edge reaches the sequencer while the busy flag is high is ignored. A request that stays high does not trigger again, either after busy clears or after a wake.
- R8: While awake, `wake_n` has no effect: `hib_n` and `core_ready` stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the strobe capture and flag read-back |
| rst_n | input | 1 | Synchronous active-low reset, held for several reference cycles |
| ref_clk | input | 1 | 32.768 kHz reference clock that paces all sequencing |
| hib_req | input | 1 | Hibernate request level from software, system domain |
| wake_n | input | 1 | Asynchronous active-low wake pin |
| reg_wr | input | 1 | One-cycle strobe marking a retained-register write, system domain |
| hib_n | output | 1 | Active-low regulator disable, launched from a reference rising edge |
| core_ready | output | 1 | Supplies settled and core may run, system domain |
| wr_busy | output | 1 | Retained-register write in progress, system domain |

## Verification
The bench counts reference edges from each stimulus and checks the edges on both sides of every timing boundary. A wake qualifier that is one cycle short would accept a single-edge glitch and leave hibernation. One that releases `hib_n` too early or too late would show the wrong level at the third or fourth edge. A settling counter that is off by one would raise `core_ready` at the twelfth or fourteenth edge instead of the thirteenth. The bench also raises a request one reference cycle after a write strobe and keeps it high afterwards. A sequencer that ignores the busy flag, or that acts on the request level instead of its rising edge, would then power down when it should not.

// File: rtl/hib_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the hibernation sequencer.
// Assumes: a single sequencer instance uses these states in the reference domain.
package hib_seq_pkg;

    typedef enum logic [2:0] {
        ST_AWAKE  = 3'd0,
        ST_ENTER  = 3'd1,
        ST_HIB    = 3'd2,
        ST_WQUAL  = 3'd3,
        ST_PWRUP  = 3'd4
    } hib_state_e;

endpackage

// File: rtl/hib_seq_sync.sv
`timescale 1ns/1ps
// Module: multi-stage flop synchronizer for one bit.
// Assumes: STAGES >= 2; d is either asynchronous or from another clock;
// rst_n is synchronous to clk.
module hib_seq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/hib_seq_wrbusy.sv
`timescale 1ns/1ps
// Module: retained-register write timer in the reference domain.
// Assumes: wr_tog_s is a synchronized toggle that flips once per write;
// writes are spaced by at least BUSY_CYC reference cycles.
module hib_seq_wrbusy #(
    parameter int BUSY_CYC = 3
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic wr_tog_s,
    output logic busy
);

    localparam int BW = $clog2(BUSY_CYC + 1);
    localparam logic [BW-1:0] BUSY_LAST = BW'(BUSY_CYC);

    logic          tog_d;
    logic          wr_evt;
    logic [BW-1:0] bcnt;
    logic          busy_q;

    assign wr_evt = wr_tog_s ^ tog_d;

    // Track the previous toggle level to find write events.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) tog_d <= 1'b0;
        else        tog_d <= wr_tog_s;
    end

    // Hold busy for BUSY_CYC cycles after each write event.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            bcnt   <= '0;
        end else if (wr_evt) begin
            busy_q <= 1'b1;
            bcnt   <= BW'(1);
        end else if (busy_q) begin
            if (bcnt == BUSY_LAST) busy_q <= 1'b0;
            else                   bcnt   <= bcnt + BW'(1);
        end
    end

    assign busy = busy_q;

    // R5: busy never drops after fewer than three high cycles.
    p_busy_len_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(busy_q, 2) && $past(busy_q, 3)));

endmodule

// File: rtl/hib_seq_fsm.sv
`timescale 1ns/1ps
// Module: hibernation state machine in the reference domain.
// Assumes: req_s and wake_s are already synchronized to ref_clk;
// WAKE_MIN >= 2 and PWR_CYC >= 1.
module hib_seq_fsm
    import hib_seq_pkg::*;
#(
    parameter int WAKE_MIN = 2,
    parameter int PWR_CYC  = 9
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic wake_s,
    input  logic busy,
    output logic hib_n,
    output logic ready
);

    localparam int QW = $clog2(WAKE_MIN + 1);
    localparam int PW = $clog2(PWR_CYC + 1);
    localparam logic [QW-1:0] QMIN  = QW'(WAKE_MIN);
    localparam logic [PW-1:0] PLAST = PW'(PWR_CYC);

    hib_state_e    state;
    logic          req_d;
    logic          req_rise;
    logic [QW-1:0] qcnt;
    logic [PW-1:0] pcnt;
    logic          hib_n_q;
    logic          ready_q;

    assign req_rise = req_s & ~req_d;

    // Sequence the power states and drive the registered outputs.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            state   <= ST_AWAKE;
            req_d   <= 1'b0;
            qcnt    <= '0;
            pcnt    <= '0;
            hib_n_q <= 1'b1;
            ready_q <= 1'b1;
        end else begin
            req_d <= req_s;
            case (state)
                ST_AWAKE: begin
                    if (req_rise && !busy) begin
                        state   <= ST_ENTER;
                        ready_q <= 1'b0;
                    end
                end
                ST_ENTER: begin
                    state   <= ST_HIB;
                    hib_n_q <= 1'b0;
                end
                ST_HIB: begin
                    if (!wake_s) begin
                        state <= ST_WQUAL;
                        qcnt  <= QW'(1);
                    end
                end
                ST_WQUAL: begin
                    if (wake_s) begin
                        state <= ST_HIB;
                    end else if (qcnt + QW'(1) >= QMIN) begin
                        state   <= ST_PWRUP;
                        hib_n_q <= 1'b1;
                        pcnt    <= PW'(1);
                    end else begin
                        qcnt <= qcnt + QW'(1);
                    end
                end
                ST_PWRUP: begin
                    if (pcnt == PLAST) begin
                        state   <= ST_AWAKE;
                        ready_q <= 1'b1;
                    end else begin
                        pcnt <= pcnt + PW'(1);
                    end
                end
                default: state <= ST_AWAKE;
            endcase
        end
    end

    assign hib_n = hib_n_q;
    assign ready = ready_q;

    // R2: regulators come back only after two low wake samples in a row.
    p_wake_qual_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(hib_n_q) |-> (!$past(wake_s) && !$past(wake_s, 2)));

    // R4: core-ready is withdrawn before the regulators are switched off.
    p_entry_order_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(hib_n_q) |-> !$past(ready_q));

    // R6: ready is never reported while the supplies are gated.
    p_ready_hib_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ready_q |-> hib_n_q);

    // R7: a busy write blocks entry into hibernation.
    p_busy_block_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state == ST_AWAKE && busy) |=> (state != ST_ENTER));

endmodule

// File: rtl/hib_power_seq.sv
`timescale 1ns/1ps
// Module: top of the hibernation wake and power sequencer.
// Assumes: rst_n is held low for several reference cycles; reg_wr strobes
// are one system cycle wide and spaced by more than the busy interval.
module hib_power_seq #(
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_MIN    = 2,
    parameter int PWR_CYC     = 9,
    parameter int BUSY_CYC    = 3
) (
    input  logic sys_clk,
    input  logic rst_n,
    input  logic ref_clk,
    input  logic hib_req,
    input  logic wake_n,
    input  logic reg_wr,
    output logic hib_n,
    output logic core_ready,
    output logic wr_busy
);

    logic wr_tog;
    logic wr_tog_s;
    logic req_s;
    logic wake_s;
    logic busy_ref;
    logic ready_ref;

    // Turn each write strobe into a level change that survives the crossing.
    always_ff @(posedge sys_clk) begin
        if (!rst_n)      wr_tog <= 1'b0;
        else if (reg_wr) wr_tog <= ~wr_tog;
    end

    hib_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_wake (
        .clk(ref_clk), .rst_n(rst_n), .d(wake_n), .q(wake_s));

    hib_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_req (
        .clk(ref_clk), .rst_n(rst_n), .d(hib_req), .q(req_s));

    hib_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_wr (
        .clk(ref_clk), .rst_n(rst_n), .d(wr_tog), .q(wr_tog_s));

    hib_seq_wrbusy #(.BUSY_CYC(BUSY_CYC)) u_wrbusy (
        .ref_clk(ref_clk), .rst_n(rst_n), .wr_tog_s(wr_tog_s), .busy(busy_ref));

    hib_seq_fsm #(.WAKE_MIN(WAKE_MIN), .PWR_CYC(PWR_CYC)) u_fsm (
        .ref_clk(ref_clk), .rst_n(rst_n), .req_s(req_s), .wake_s(wake_s),
        .busy(busy_ref), .hib_n(hib_n), .ready(ready_ref));

    hib_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_ready (
        .clk(sys_clk), .rst_n(rst_n), .d(ready_ref), .q(core_ready));

    hib_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_busy (
        .clk(sys_clk), .rst_n(rst_n), .d(busy_ref), .q(wr_busy));

endmodule

// File: tb/hib_power_seq_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, reference clock 20x slower than sys.
module hib_power_seq_bench;

    logic sys_clk = 1'b0;
    logic ref_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic hib_req = 1'b0;
    logic wake_n  = 1'b1;
    logic reg_wr  = 1'b0;
    logic hib_n;
    logic core_ready;
    logic wr_busy;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10  sys_clk = ~sys_clk;
    always #200 ref_clk = ~ref_clk;

    hib_power_seq u_hib_power_seq (
        .sys_clk(sys_clk), .rst_n(rst_n), .ref_clk(ref_clk),
        .hib_req(hib_req), .wake_n(wake_n), .reg_wr(reg_wr),
        .hib_n(hib_n), .core_ready(core_ready), .wr_busy(wr_busy));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic ref_edges(input int n);
        repeat (n) @(posedge ref_clk);
        #100;
    endtask

    task automatic pulse_wr();
        reg_wr = 1'b1;
        @(negedge sys_clk);
        reg_wr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (6) @(posedge ref_clk);
        @(negedge sys_clk) rst_n = 1'b1;
        repeat (5) @(posedge sys_clk);
        #1;
        check(hib_n == 1'b1, "R1 hib_n after reset", hib_n, 1);
        check(core_ready == 1'b1, "R1 core_ready after reset", core_ready, 1);
        check(wr_busy == 1'b0, "R1 wr_busy after reset", wr_busy, 0);
    endtask

    task automatic t_wake_while_awake();
        @(negedge ref_clk) wake_n = 1'b0;
        repeat (4) @(negedge ref_clk);
        wake_n = 1'b1;
        ref_edges(4);
        check(hib_n == 1'b1, "R8 hib_n with wake while awake", hib_n, 1);
        check(core_ready == 1'b1, "R8 core_ready with wake while awake", core_ready, 1);
    endtask

    task automatic t_write_busy();
        int first = -1;
        int width = 0;
        @(negedge ref_clk);
        pulse_wr();
        for (int i = 0; i < 400; i++) begin
            @(posedge sys_clk);
            #1;
            if (wr_busy) begin
                if (first < 0) first = i;
                width++;
            end
        end
        check(first >= 0 && first <= 80, "R5 busy rise delay", first, 80);
        check(width >= 59 && width <= 61, "R5 busy width in sys cycles", width, 60);
    endtask

    task automatic t_busy_blocks_request();
        @(negedge ref_clk);
        pulse_wr();
        @(negedge ref_clk) hib_req = 1'b1;
        ref_edges(10);
        check(hib_n == 1'b1, "R7 hib_n with request during busy", hib_n, 1);
        check(core_ready == 1'b1, "R7 core_ready with request during busy", core_ready, 1);
        @(negedge ref_clk) hib_req = 1'b0;
        ref_edges(4);
    endtask

    task automatic t_enter();
        @(negedge ref_clk) hib_req = 1'b1;
        ref_edges(3);
        check(core_ready == 1'b0, "R4 core_ready at third edge", core_ready, 0);
        check(hib_n == 1'b1, "R4 hib_n at third edge", hib_n, 1);
        ref_edges(1);
        check(hib_n == 1'b0, "R4 hib_n at fourth edge", hib_n, 0);
    endtask

    task automatic t_short_wake();
        @(negedge ref_clk) wake_n = 1'b0;
        @(negedge ref_clk) wake_n = 1'b1;
        ref_edges(12);
        check(hib_n == 1'b0, "R2 hib_n after one-edge wake", hib_n, 0);
        check(core_ready == 1'b0, "R2 core_ready after one-edge wake", core_ready, 0);
    endtask

    task automatic t_wake();
        @(negedge ref_clk) wake_n = 1'b0;
        ref_edges(3);
        check(hib_n == 1'b0, "R3 hib_n at third edge after wake", hib_n, 0);
        ref_edges(1);
        check(hib_n == 1'b1, "R2 R3 hib_n at fourth edge after wake", hib_n, 1);
        check(core_ready == 1'b0, "R6 core_ready right after release", core_ready, 0);
        @(negedge ref_clk) wake_n = 1'b1;
        ref_edges(8);
        check(core_ready == 1'b0, "R6 core_ready eight cycles after release", core_ready, 0);
        ref_edges(1);
        check(core_ready == 1'b1, "R6 core_ready nine cycles after release", core_ready, 1);
    endtask

    task automatic t_no_reentry();
        ref_edges(6);
        check(hib_n == 1'b1, "R7 hib_n with request held after wake", hib_n, 1);
        check(core_ready == 1'b1, "R7 core_ready with request held after wake", core_ready, 1);
        @(negedge ref_clk) hib_req = 1'b0;
        ref_edges(2);
    endtask

    initial begin
        t_reset();
        t_wake_while_awake();
        t_write_busy();
        t_busy_blocks_request();
        t_enter();
        t_short_wake();
        t_wake();
        t_no_reentry();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge sys_clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule